// File: doc/BRIEF.md
# Byte-Indexed Table Lookup Unit

The unit assembles a 32-bit word from four independent byte lanes. Each lane of the index word carries an 8-bit byte address into a small lookup table. The table is one to four 64-bit registers presented on a flat input bus, and a count input gives how many of them hold valid data. A lane whose address falls inside the valid part of the table returns the addressed table byte. A lane whose address falls outside it returns the byte in the same lane of a separate fallback word.

The unit does no register-file reads of its own and decodes nothing. A caller presents the index word, the fallback word, the table registers and the count together with a one-cycle strobe. One clock edge later the assembled word appears on the result port, marked by a valid flag. The result holds its value until the next strobe.

Top module: `byte_table_lookup`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `result` are cleared to 0 at that edge.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and `result` takes the new lookup value at that same edge. With no strobe, `out_valid` is 0 in the next cycle.
- R3: When `in_valid` is low, `result` keeps its previous value, whatever the other inputs do.
- R4: Lane k (k = 0..3) uses index bits [8k+7:8k] and fallback bits [8k+7:8k], and writes result bits [8k+7:8k]. The lanes do not affect each other.
- R5: A lane index is in range only if it is strictly less than 8 × N, where N is `tbl_count`. A count above 4 is treated as 4. A count of 0 makes every lane out of range.
- R6: For an in-range index, index / 8 selects table register r, which is `tbl_data[64r+63:64r]`.
- R7: For an in-range index, index mod 8 selects the byte within that register. Byte 0 is bits [7:0] of the register.
- R8: An out-of-range lane outputs the fallback byte from the same lane position.
- R9: Any index of 32 or more, up to and including 255, is always out of range, for every count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: capture a lookup at this edge |
| index_word | input | 32 | Four byte-wide lane indices |
| fallback_word | input | 32 | Bytes used by out-of-range lanes |
| tbl_data | input | 256 | Up to four 64-bit table registers, register 0 in the low bits |
| tbl_count | input | 3 | Number of valid table registers |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Assembled lookup word |

## Verification
All four lanes are computed by combinational logic and pass through a single register. A strobe therefore gives its result and `out_valid` at the first rising edge after it, and no later edge changes either one until another strobe arrives. The bench drives every stimulus on a falling edge and samples one falling edge later, which is half a period after the edge that loads the result. It keeps the strobe low on the following cycle and changes the inputs, so that it can see the result hold and the valid flag drop.

// File: rtl/tbl_lookup_pkg.sv
// Shared constants and types for the byte table lookup unit.
// Assumes byte-wide lanes and 64-bit table registers throughout.
package tbl_lookup_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned REG_W  = 64;
    localparam int unsigned BYTES_PER_REG = REG_W / BYTE_W;
    typedef logic [BYTE_W-1:0] lane_byte_t;
endpackage

// File: rtl/tbl_limit_calc.sv
// Turns the table register count into the table length in bytes.
// Assumes a count above MAX_REGS means MAX_REGS; zero gives an empty table.
module tbl_limit_calc #(
    parameter int unsigned MAX_REGS = 4,
    parameter int unsigned CNT_W    = $clog2(MAX_REGS + 1),
    parameter int unsigned LIM_W    = 9
) (
    input  logic [CNT_W-1:0] count,
    output logic [LIM_W-1:0] limit
);
    import tbl_lookup_pkg::*;
    localparam int unsigned SHIFT = $clog2(BYTES_PER_REG);

    logic [CNT_W-1:0] eff_count;

    // Clamp the count to the number of registers that exist.
    always_comb begin
        if (count > CNT_W'(MAX_REGS)) eff_count = CNT_W'(MAX_REGS);
        else                          eff_count = count;
    end

    // Scale the register count to a byte count.
    always_comb limit = LIM_W'(eff_count) << SHIFT;
endmodule

// File: rtl/tbl_lane_pick.sv
// One lane: picks a table byte for an in-range index, else the fallback byte.
// Assumes the table is a flat bus with byte p at bits [8p+7:8p].
module tbl_lane_pick #(
    parameter int unsigned TABLE_BYTES = 32,
    parameter int unsigned LIM_W       = 9
) (
    input  tbl_lookup_pkg::lane_byte_t                     idx,
    input  tbl_lookup_pkg::lane_byte_t                     fallback,
    input  logic [TABLE_BYTES*tbl_lookup_pkg::BYTE_W-1:0]  table_bus,
    input  logic [LIM_W-1:0]                               limit,
    output tbl_lookup_pkg::lane_byte_t                     pick
);
    import tbl_lookup_pkg::*;
    localparam int unsigned ADDR_W = $clog2(TABLE_BYTES);
    localparam int unsigned SH     = $clog2(BYTE_W);
    localparam int unsigned BASE_W = ADDR_W + SH;

    logic              in_range;
    logic [ADDR_W-1:0] addr;
    logic [BASE_W-1:0] base;
    lane_byte_t        tbl_byte;

    // Range check against the current table length.
    always_comb in_range = (LIM_W'(idx) < limit);

    // Register select is addr/8, byte select addr%8: one flat byte address.
    always_comb begin
        addr     = idx[ADDR_W-1:0];
        base     = {addr, {SH{1'b0}}};
        tbl_byte = table_bus[base +: BYTE_W];
    end

    // Final lane mux between table and fallback.
    always_comb pick = in_range ? tbl_byte : fallback;
endmodule

// File: rtl/tbl_result_reg.sv
// Output stage: loads the assembled word on a strobe and flags it valid.
// Assumes a synchronous active-low reset.
module tbl_result_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         vld,
    output logic [W-1:0] q
);
    // Capture the word on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= load;
            if (load) q <= d;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!vld && q == '0));
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> vld);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !vld);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/byte_table_lookup.sv
// Top: four independent byte lanes look up a 1..MAX_REGS register table,
// with a fallback byte per lane for out-of-range indices; one register stage.
// Assumes the caller holds inputs stable only in the strobe cycle.
module byte_table_lookup #(
    parameter int unsigned LANES    = 4,
    parameter int unsigned MAX_REGS = 4,
    parameter int unsigned CNT_W    = $clog2(MAX_REGS + 1)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  logic [LANES*8-1:0]                      index_word,
    input  logic [LANES*8-1:0]                      fallback_word,
    input  logic [MAX_REGS*64-1:0]                  tbl_data,
    input  logic [CNT_W-1:0]                        tbl_count,
    output logic                                    out_valid,
    output logic [LANES*8-1:0]                      result
);
    import tbl_lookup_pkg::*;
    localparam int unsigned TABLE_BYTES = MAX_REGS * BYTES_PER_REG;
    localparam int unsigned LIM_W       = BYTE_W + 1;
    localparam int unsigned WORD_W      = LANES * BYTE_W;

    logic [LIM_W-1:0]  limit;
    logic [WORD_W-1:0] word_next;

    tbl_limit_calc #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W), .LIM_W(LIM_W)) limit_i (
        .count (tbl_count),
        .limit (limit)
    );

    p_limit_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        limit <= LIM_W'(TABLE_BYTES));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tbl_lane_pick #(.TABLE_BYTES(TABLE_BYTES), .LIM_W(LIM_W)) lane_i (
            .idx       (index_word[k*BYTE_W +: BYTE_W]),
            .fallback  (fallback_word[k*BYTE_W +: BYTE_W]),
            .table_bus (tbl_data),
            .limit     (limit),
            .pick      (word_next[k*BYTE_W +: BYTE_W])
        );

        p_oob_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && LIM_W'(index_word[k*BYTE_W +: BYTE_W]) >= limit)
            |=> result[k*BYTE_W +: BYTE_W] == $past(fallback_word[k*BYTE_W +: BYTE_W]));
        p_high_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && index_word[k*BYTE_W +: BYTE_W] >= BYTE_W'(TABLE_BYTES))
            |=> result[k*BYTE_W +: BYTE_W] == $past(fallback_word[k*BYTE_W +: BYTE_W]));
        p_first_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && index_word[k*BYTE_W +: BYTE_W] == '0 && tbl_count != '0)
            |=> result[k*BYTE_W +: BYTE_W] == $past(tbl_data[BYTE_W-1:0]));
    end

    tbl_result_reg #(.W(WORD_W)) out_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .d     (word_next),
        .vld   (out_valid),
        .q     (result)
    );
endmodule

// File: tb/byte_table_lookup_tb.sv
module byte_table_lookup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int WATCHDOG = 20000;

    // {index word, count, expected}; table byte p = 0xA0+p, fallback 0x11223344
    localparam logic [31:0] V_IDX [NVEC] = '{32'h03020100, 32'h1F181007, 32'h20FF1F00,
        32'h08070807, 32'h100F100F, 32'h18171817, 32'h00000000, 32'h1F00201F};
    localparam logic [2:0]  V_CNT [NVEC] = '{3'd4, 3'd4, 3'd4, 3'd1, 3'd2, 3'd3, 3'd0, 3'd7};
    localparam logic [31:0] V_EXP [NVEC] = '{32'hA3A2A1A0, 32'hBFB8B0A7, 32'h1122BFA0,
        32'h11A733A7, 32'h11AF33AF, 32'h11B733B7, 32'h11223344, 32'hBFA033BF};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  index_word = '0;
    logic [31:0]  fallback_word = 32'h11223344;
    logic [255:0] tbl_data = '0;
    logic [2:0]   tbl_count = 3'd4;
    logic         out_valid;
    logic [31:0]  result;
    int           n_chk = 0;
    int           n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_table_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .index_word(index_word),
        .fallback_word(fallback_word), .tbl_data(tbl_data), .tbl_count(tbl_count),
        .out_valid(out_valid), .result(result)
    );

    // Behavioural model written from the requirements (R4..R9).
    function automatic logic [31:0] model(input logic [31:0] idx, input logic [31:0] fb,
                                          input logic [255:0] t, input logic [2:0] cnt);
        logic [31:0] r;
        int n;
        n = (cnt > 3'd4) ? 32 : int'(cnt) * 8;
        for (int k = 0; k < 4; k++) begin
            int i;
            i = int'(idx[k*8 +: 8]);
            if (i < n) r[k*8 +: 8] = t[(i/8)*64 + (i%8)*8 +: 8];
            else       r[k*8 +: 8] = fb[k*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe one lookup, sample half a period after the loading edge.
    task automatic apply(input logic [31:0] idx, input logic [2:0] cnt,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        index_word = idx; tbl_count = cnt; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({31'd0, out_valid}, 32'd1, "R2 valid");
        check(result, exp, req);
    endtask

    initial begin
        for (int p = 0; p < 32; p++) tbl_data[p*8 +: 8] = 8'hA0 + 8'(p);
        index_word = 32'h03020100; in_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        check({31'd0, out_valid}, 32'd0, "R1 valid");
        check(result, 32'd0, "R1 result");
        rst_n = 1'b1; in_valid = 1'b0;

        // Table walk: R4 lanes, R5 length, R6/R7 selection, R8/R9 fallback.
        for (int v = 0; v < NVEC; v++)
            apply(V_IDX[v], V_CNT[v], V_EXP[v], "R4-vector");

        // R3: inputs change without a strobe, result holds and valid drops.
        @(negedge clk);
        index_word = 32'h05050505; fallback_word = 32'hDEADBEEF; tbl_count = 3'd4;
        @(negedge clk);
        check(result, V_EXP[NVEC-1], "R3 hold");
        check({31'd0, out_valid}, 32'd0, "R2 no strobe");

        // R9: 255 and 32 stay out of range at every count.
        for (int c = 0; c < 8; c++)
            apply(32'hFF20FF20, 3'(c), 32'hDEADBEEF, "R9 high index");

        // R5 boundary: index equal to length is fallback, one below is table.
        for (int c = 1; c <= 4; c++)
            apply({8'(c*8), 8'(c*8-1), 8'(c*8), 8'(c*8-1)}, 3'(c),
                  {8'hDE, 8'hA0 + 8'(c*8-1), 8'hBE, 8'hA0 + 8'(c*8-1)}, "R5 boundary");

        // Random: R6/R7/R8 against the model, with varied tables.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] idx;
            idx = $urandom;
            if (n % 2 == 0) idx = idx & 32'h3F3F3F3F;
            fallback_word = $urandom;
            for (int w = 0; w < 8; w++) tbl_data[w*32 +: 32] = $urandom;
            tbl_count = 3'($urandom_range(0, 7));
            apply(idx, tbl_count, model(idx, fallback_word, tbl_data, tbl_count), "R6/R7/R8 random");
        end

        // R1 again: reset mid-run clears the stage.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(result, 32'd0, "R1 rerun");
        check({31'd0, out_valid}, 32'd0, "R1 rerun valid");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule